// File: doc/BRIEF.md
# Video Input Planar Splitter

This block sits behind a camera-style source that delivers 8-bit YUV 4:2:2 samples, one byte per valid clock, in the repeating order Cb, Y, Cr, Y. It sorts every byte into one of three planes (luma, blue-difference chroma, red-difference chroma). It packs each plane's bytes four at a time into 32-bit words and issues each completed word as a write request with its own address toward a single memory write port. Each plane has a pointer that starts at a base address and walks upward, so the captured frame lands in three separate planar buffers.

Software sets the three base addresses and the number of lines per frame, then leaves the block alone. A frame-start marker rewinds everything. A line-end marker flushes any partial words, zero-padded, over the next three cycles. When the programmed number of lines has ended, a sticky interrupt bit is raised. It stays up until a write-one-to-clear pulse removes it.

Top module: `vid_plane_splitter`

## Requirements
- R1: While and right after reset, `wr_valid` and `frame_irq` are 0.
- R2: A valid byte's plane follows a 2-bit byte phase that restarts at 0 on frame start and on line end: phase 0 goes to plane U (`wr_plane`=1), phases 1 and 3 to plane Y (`wr_plane`=0), phase 2 to plane V (`wr_plane`=2).
- R3: Bytes of one plane are packed little-endian, the first byte in bits 7:0. The write carrying the fourth byte appears with `wr_valid`=1 one cycle after that byte is taken.
- R4: Each plane's write address starts at its base on frame start and rises by 4 after each write to that plane. Bases are word aligned, so addresses have bits 1:0 equal to 0.
- R5: On a line-end pulse, the next three cycles are flush slots for Y, U and V in that order. A plane holding 1 to 3 bytes writes them with zero in the unused upper bytes. An empty plane skips its slot. The source leaves at least three idle cycles after line end.
- R6: `frame_irq` rises together with the V flush slot of the line end that brings the line count to `frame_lines`. The line count then restarts at 0.
- R7: `frame_irq` stays 1 until a cycle with `irq_clr`=1 and no new set. A set in the same cycle as a clear wins.
- R8: Frame start discards partial words and the line count, rewinds all three pointers and produces no write in the following cycle.
- R9: Bytes presented with `pix_valid`=0 produce no write, and neither the packing nor the phase changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 8 | Incoming sample byte |
| pix_valid | input | 1 | `pix_data` holds a sample this cycle |
| frame_start | input | 1 | Frame start marker, one cycle |
| line_end | input | 1 | Line end marker, one cycle, no data |
| base_y | input | AW | Luma plane base address |
| base_u | input | AW | Cb plane base address |
| base_v | input | AW | Cr plane base address |
| frame_lines | input | LW | Lines per frame |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| wr_valid | output | 1 | Write request this cycle |
| wr_plane | output | 2 | Target plane: 0 Y, 1 U, 2 V |
| wr_addr | output | AW | Byte address of the word |
| wr_data | output | 32 | Packed word |
| frame_irq | output | 1 | Sticky frame-complete interrupt |

## Verification
A word write is due one clock after the byte that completes it. Flush writes are due one, two and three clocks after the line-end cycle, and the interrupt rises with the third of these. The bench's reference model advances on the same rising edge as the design and works out what each output must show after that edge. Every output is then compared at the falling edge that follows, so each result is checked in exactly the cycle it is due and never a cycle early or late. Explicit checks at chosen points cover reset, the sticky hold and the clear.

// File: rtl/vid_plane_splitter.sv
module vid_plane_splitter #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    pix_data,
  input  logic          pix_valid,
  input  logic          frame_start,
  input  logic          line_end,
  input  logic [AW-1:0] base_y,
  input  logic [AW-1:0] base_u,
  input  logic [AW-1:0] base_v,
  input  logic [LW-1:0] frame_lines,
  input  logic          irq_clr,
  output logic          wr_valid,
  output logic [1:0]    wr_plane,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          frame_irq
);

  localparam logic [AW-1:0] STEP = AW'(4);

  logic [AW-1:0] ptr [3];
  logic [23:0]   acc [3];
  logic [1:0]    cnt [3];
  logic [1:0]    phase;
  logic          flushing;
  logic [1:0]    fidx;
  logic [LW-1:0] lines;
  logic          last_line;

  wire [LW-1:0] lines_nx = lines + 1'b1;
  wire          at_last  = (lines_nx == frame_lines);
  wire [1:0]    sel      = phase[0] ? 2'd0 : (phase[1] ? 2'd2 : 2'd1);
  wire          irq_set  = !frame_start && flushing && (fidx == 2'd2) && last_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        ptr[i] <= '0;
        acc[i] <= '0;
        cnt[i] <= '0;
      end
      phase     <= '0;
      flushing  <= 1'b0;
      fidx      <= '0;
      lines     <= '0;
      last_line <= 1'b0;
      wr_valid  <= 1'b0;
      wr_plane  <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      frame_irq <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (frame_start) begin
        ptr[0] <= base_y;
        ptr[1] <= base_u;
        ptr[2] <= base_v;
        for (int i = 0; i < 3; i++) begin
          acc[i] <= '0;
          cnt[i] <= '0;
        end
        phase    <= '0;
        lines    <= '0;
        flushing <= 1'b0;
        fidx     <= '0;
      end else if (flushing) begin
        if (cnt[fidx] != 2'd0) begin
          wr_valid   <= 1'b1;
          wr_plane   <= fidx;
          wr_addr    <= ptr[fidx];
          wr_data    <= {8'h00, acc[fidx]};
          ptr[fidx]  <= ptr[fidx] + STEP;
          acc[fidx]  <= '0;
          cnt[fidx]  <= '0;
        end
        if (fidx == 2'd2) begin
          flushing <= 1'b0;
          fidx     <= '0;
        end else begin
          fidx <= fidx + 2'd1;
        end
      end else if (line_end) begin
        flushing  <= 1'b1;
        fidx      <= '0;
        phase     <= '0;
        last_line <= at_last;
        lines     <= at_last ? '0 : lines_nx;
      end else if (pix_valid) begin
        if (cnt[sel] == 2'd3) begin
          wr_valid  <= 1'b1;
          wr_plane  <= sel;
          wr_addr   <= ptr[sel];
          wr_data   <= {pix_data, acc[sel]};
          ptr[sel]  <= ptr[sel] + STEP;
          acc[sel]  <= '0;
          cnt[sel]  <= '0;
        end else begin
          acc[sel][{cnt[sel], 3'b000} +: 8] <= pix_data;
          cnt[sel] <= cnt[sel] + 2'd1;
        end
        phase <= phase + 2'd1;
      end
      if (irq_set)
        frame_irq <= 1'b1;
      else if (irq_clr)
        frame_irq <= 1'b0;
    end
  end

endmodule

// File: rtl/vid_plane_splitter_chk.sv
module vid_plane_splitter_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          irq_clr,
  input logic          wr_valid,
  input logic [1:0]    wr_plane,
  input logic [AW-1:0] wr_addr,
  input logic          frame_irq
);

  p_quiet_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!wr_valid && !frame_irq));

  p_plane_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_plane != 2'd3));

  p_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));

  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && !irq_clr) |=> frame_irq);

  p_irq_fall_needs_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_irq) |-> $past(irq_clr));

  p_sof_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !wr_valid);

endmodule

bind vid_plane_splitter vid_plane_splitter_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .irq_clr(irq_clr),
  .wr_valid(wr_valid), .wr_plane(wr_plane), .wr_addr(wr_addr),
  .frame_irq(frame_irq)
);

// File: tb/vid_plane_splitter_tb.sv
module vid_plane_splitter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    pix_data = '0;
  logic          pix_valid = 1'b0;
  logic          frame_start = 1'b0;
  logic          line_end = 1'b0;
  logic [AW-1:0] base_y = 32'h0000_1000;
  logic [AW-1:0] base_u = 32'h0000_2000;
  logic [AW-1:0] base_v = 32'h0000_3000;
  logic [LW-1:0] frame_lines = 12'd2;
  logic          irq_clr = 1'b0;
  logic          wr_valid;
  logic [1:0]    wr_plane;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          frame_irq;

  vid_plane_splitter #(.AW(AW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .pix_valid(pix_valid),
    .frame_start(frame_start), .line_end(line_end), .base_y(base_y),
    .base_u(base_u), .base_v(base_v), .frame_lines(frame_lines),
    .irq_clr(irq_clr), .wr_valid(wr_valid), .wr_plane(wr_plane),
    .wr_addr(wr_addr), .wr_data(wr_data), .frame_irq(frame_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  int        m_ptr [3];
  int        m_cnt [3];
  bit [7:0]  m_byte [3][4];
  int        m_phase, m_lines, m_fidx;
  bit        m_flush, m_last;
  bit        ev, eirq;
  int        ea, ep;
  bit [31:0] ed;
  string     etag;

  task automatic emit(input int p, input string tag);
    ev = 1; ep = p; ea = m_ptr[p]; etag = tag;
    ed = {m_byte[p][3], m_byte[p][2], m_byte[p][1], m_byte[p][0]};
    m_ptr[p] += 4;
    m_cnt[p] = 0;
    for (int k = 0; k < 4; k++) m_byte[p][k] = 8'h00;
  endtask

  always @(posedge clk) begin
    bit set;
    set = 0;
    ev = 0;
    if (!rst_n) begin
      eirq = 0; m_phase = 0; m_lines = 0; m_flush = 0; m_fidx = 0; m_last = 0;
      for (int p = 0; p < 3; p++) begin
        m_ptr[p] = 0; m_cnt[p] = 0;
        for (int k = 0; k < 4; k++) m_byte[p][k] = 8'h00;
      end
    end else begin
      if (frame_start) begin
        m_ptr[0] = int'(base_y); m_ptr[1] = int'(base_u); m_ptr[2] = int'(base_v);
        for (int p = 0; p < 3; p++) begin
          m_cnt[p] = 0;
          for (int k = 0; k < 4; k++) m_byte[p][k] = 8'h00;
        end
        m_phase = 0; m_lines = 0; m_flush = 0; m_fidx = 0;
      end else if (m_flush) begin
        if (m_cnt[m_fidx] > 0) emit(m_fidx, "R5");
        if (m_fidx == 2) begin
          m_flush = 0; m_fidx = 0;
          if (m_last) set = 1;
        end else m_fidx++;
      end else if (line_end) begin
        m_flush = 1; m_fidx = 0; m_phase = 0;
        m_lines++;
        m_last = (m_lines == int'(frame_lines));
        if (m_last) m_lines = 0;
      end else if (pix_valid) begin
        int p;
        p = (m_phase % 2 == 1) ? 0 : ((m_phase == 0) ? 1 : 2);
        m_byte[p][m_cnt[p]] = pix_data;
        m_cnt[p]++;
        if (m_cnt[p] == 4) emit(p, "R3");
        m_phase = (m_phase + 1) % 4;
      end
      if (set) eirq = 1;
      else if (irq_clr) eirq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(wr_valid == ev, ev ? etag : "R9", longint'(wr_valid), longint'(ev));
      if (wr_valid && ev) begin
        check(wr_plane == 2'(ep), "R2", longint'(wr_plane), longint'(ep));
        check(wr_addr == AW'(ea), "R4", longint'(wr_addr), longint'(ea));
        check(wr_data == ed, etag, longint'(wr_data), longint'(ed));
      end
      check(frame_irq == eirq, "R6", longint'(frame_irq), longint'(eirq));
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic send(input logic [7:0] d);
    pix_valid = 1'b1; pix_data = d; tick(); pix_valid = 1'b0; pix_data = 8'hEE;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic noise(input logic [7:0] d);
    pix_valid = 1'b0; pix_data = d; tick(); pix_data = 8'h00;
  endtask

  task automatic sof();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic eol();
    line_end = 1'b1; tick(); line_end = 1'b0; idle(4);
  endtask

  task automatic run_end();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    run_end();
  end

  initial begin
    idle(3);
    // R1: reset state at the ports
    check(wr_valid == 1'b0, "R1", longint'(wr_valid), 0);
    check(frame_irq == 1'b0, "R1", longint'(frame_irq), 0);
    rst_n = 1'b1;
    tick();
    check(wr_valid == 1'b0 && frame_irq == 1'b0, "R1", longint'({wr_valid, frame_irq}), 0);

    // frame of two lines, full words then partial words
    sof();
    for (int i = 0; i < 16; i++) begin
      send(8'(8'h10 + i));
      if (i == 5 || i == 11) noise(8'hA5); // R9: ignored bytes
    end
    eol();
    for (int i = 0; i < 10; i++) send(8'(8'h40 + 3 * i));
    eol();
    idle(5);
    // R7: interrupt held
    check(frame_irq == 1'b1, "R7", longint'(frame_irq), 1);
    irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    idle(2);
    check(frame_irq == 1'b0, "R7", longint'(frame_irq), 0);

    // R8: abort a partial line with a new frame start
    sof();
    for (int i = 0; i < 7; i++) send(8'(8'h80 + i));
    frame_lines = 12'd1;
    sof();
    for (int i = 0; i < 13; i++) send(8'(8'hC0 + i));
    // clear held across the set cycle: set wins, then clear
    line_end = 1'b1; irq_clr = 1'b1; tick(); line_end = 1'b0;
    idle(3);
    check(frame_irq == 1'b1, "R7", longint'(frame_irq), 1);
    tick(); irq_clr = 1'b0;
    idle(2);
    check(frame_irq == 1'b0, "R7", longint'(frame_irq), 0);
    idle(4);
    run_end();
  end
endmodule